// File: doc/BRIEF.md
# Parity-Checked Reversible 4x4 Multiplier

This block multiplies two unsigned 4-bit operands in pure combinational logic. It is built only from reversible primitives that conserve parity: for every primitive, the XOR of its input lines equals the XOR of its output lines. The product is assembled the crosswise way. Each operand bit is fanned out to two copies. Four 2x2 sub-multipliers form the partial products. Two 4-bit ripple adders merge the middle terms, and a third adder produces the upper product nibble.

Every constant (ancilla) line enters at 0, and every line that does not become a product bit leaves on a garbage bus. The XOR of all outputs (product and garbage) must therefore equal the XOR of the two operands. An error flag is raised when the two sides disagree. Since each primitive conserves parity, inverting any single line between primitives flips the output-side parity and raises the flag.

A test-only fault-injection input can invert one chosen line out of 41 inter-stage lines. This lets the detection path be exercised on silicon or in a bench.

Top module: `rvm_pp_mult`

## Requirements
- R1: With `flt_en` low, `prod` equals `op_a * op_b` as an unsigned 8-bit value, for all 256 operand pairs.
- R2: With `flt_en` low, `err` is 0 for every operand pair.
- R3: With `flt_en` low, the XOR of all bits of `prod` and `garb` equals the XOR of all bits of `op_a` and `op_b`.
- R4: With `flt_en` high and `flt_sel` in 0..40, exactly one inter-stage line is inverted, and `err` is 1 for any operand pair.
- R5: With `flt_en` high and `flt_sel` in 41..63, no line is inverted: `prod` equals `op_a * op_b` and `err` is 0.
- R6: With `flt_en` low, the value on `flt_sel` has no effect on `prod` or `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| flt_en | input | 1 | Test only: enables single-line inversion |
| flt_sel | input | 6 | Test only: index of the line to invert (0..40 valid) |
| prod | output | 8 | Unsigned product |
| garb | output | 80 | Garbage lines of all primitives, left unconsumed |
| err | output | 1 | High when input-side and output-side parity differ |

## Verification
The bench builds the block with its default 4-bit operand width and the injection logic enabled (`INJECT` = 1). This brings all 41 fault points within reach of the test port. The full operand space is swept fault-free, so every partial-product and carry combination is covered, including the two middle carries that can never be high together. Each fault point is then hit under several operand patterns, including all-zero and all-one operands. This shows that detection holds whether or not the inverted line happened to carry a 1. Out-of-range selectors and a disabled enable are driven with varying selectors to show that they leave both the product and the flag untouched.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

   // Every primitive below conserves parity: ^inputs == ^outputs.
   // Bit 0 of each result is the first output line.

   // Double copy: (x, y, z) -> (x, x^y, x^z)
   function automatic logic [2:0] pp_dup(input logic x, input logic y, input logic z);
      return {x ^ z, x ^ y, x};
   endfunction

   // Two-target AND: (a, b, c, d) -> (a, b, ab^c, ab^d)
   function automatic logic [3:0] pp_and4(input logic a, input logic b,
                                          input logic c, input logic d);
      return {(a & b) ^ d, (a & b) ^ c, b, a};
   endfunction

   // Controlled swap: (s, b, c) -> (s, s'b^sc, s'c^sb)
   function automatic logic [2:0] pp_cswap(input logic s, input logic b, input logic c);
      return {(~s & c) ^ (s & b), (~s & b) ^ (s & c), s};
   endfunction

   // Half-adder cell: (a, b, c, d) -> (ab'^c, a^b, ab^c, a^c^d)
   // with c = d = 0: [1] = sum, [2] = carry
   function automatic logic [3:0] pp_ha4(input logic a, input logic b,
                                         input logic c, input logic d);
      return {a ^ c ^ d, (a & b) ^ c, a ^ b, (a & ~b) ^ c};
   endfunction

   // Full-adder cell, five lines; with d = e = 0: [2] = sum, [3] = carry
   function automatic logic [4:0] pp_fa5(input logic a, input logic b, input logic c,
                                         input logic d, input logic e);
      logic t;
      t = a ^ d;
      return {(t & (b ^ c)) ^ (b & ~c) ^ d ^ e,
              (t & (b ^ c)) ^ (b & c) ^ d,
              a ^ b ^ c ^ d,
              a ^ b ^ d,
              t};
   endfunction

   localparam int unsigned MUL2_GARB = 9;

endpackage

// File: rtl/rvm_mul2.sv
module rvm_mul2
   import rvm_pkg::*;
(
   input  logic [1:0]           x,
   input  logic [1:0]           y,
   output logic [3:0]           m,
   output logic [MUL2_GARB-1:0] g
);

   logic [3:0] and_o;
   logic [2:0] sw1_o, sw2_o, sw3_o;
   logic [3:0] ha1_o, ha2_o;

   always_comb begin
      // x0*y0 plus pass-through copies of x0, y0
      and_o = pp_and4(x[0], y[0], 1'b0, 1'b0);
      // x1*y0, control x1
      sw1_o = pp_cswap(x[1], 1'b0, and_o[1]);
      // x0*y1, control y1
      sw2_o = pp_cswap(y[1], 1'b0, and_o[0]);
      // x1*y1
      sw3_o = pp_cswap(sw1_o[0], 1'b0, sw2_o[0]);
      ha1_o = pp_ha4(sw1_o[1], sw2_o[1], 1'b0, 1'b0);
      ha2_o = pp_ha4(sw3_o[1], ha1_o[2], 1'b0, 1'b0);
   end

   assign m = {ha2_o[2], ha2_o[1], ha1_o[1], and_o[2]};
   assign g = {ha2_o[3], ha2_o[0], ha1_o[3], ha1_o[0],
               sw3_o[2], sw3_o[0], sw2_o[2], sw1_o[2], and_o[3]};

endmodule

// File: rtl/rvm_rca.sv
module rvm_rca
   import rvm_pkg::*;
#(
   parameter int unsigned N = 4,
   localparam int unsigned GW = 2 + 3 * (N - 1)
) (
   input  logic [N-1:0]  x,
   input  logic [N-1:0]  y,
   output logic [N-1:0]  s,
   output logic          co,
   output logic [GW-1:0] g
);

   logic [N:0] c;

   if (N < 2) begin : g_bad_n
      $error("rvm_rca: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_ha
         logic [3:0] h;
         assign h      = pp_ha4(x[0], y[0], 1'b0, 1'b0);
         assign s[0]   = h[1];
         assign c[1]   = h[2];
         assign g[1:0] = {h[3], h[0]};
      end else begin : g_fa
         logic [4:0] f;
         assign f      = pp_fa5(x[i], y[i], c[i], 1'b0, 1'b0);
         assign s[i]   = f[2];
         assign c[i+1] = f[3];
         assign g[2+3*(i-1) +: 3] = {f[4], f[1], f[0]};
      end
   end

   assign c[0] = 1'b0;
   assign co   = c[N];

endmodule

// File: rtl/rvm_pp_mult.sv
module rvm_pp_mult
   import rvm_pkg::*;
#(
   parameter int unsigned OP_W   = 4,
   parameter bit          INJECT = 1'b1,
   localparam int unsigned HALF   = OP_W / 2,
   localparam int unsigned PROD_W = 2 * OP_W,
   localparam int unsigned NPTS   = 4 * OP_W + 4 * OP_W + (OP_W + 1) + 3 + 1,
   localparam int unsigned SEL_W  = $clog2(NPTS),
   localparam int unsigned RCA_G  = 2 + 3 * (OP_W - 1),
   localparam int unsigned GARB_W = 4 * MUL2_GARB + 2 * OP_W + 3 * RCA_G + 3
) (
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic              flt_en,
   input  logic [SEL_W-1:0]  flt_sel,
   output logic [PROD_W-1:0] prod,
   output logic [GARB_W-1:0] garb,
   output logic              err
);

   localparam int unsigned CP_W  = 2 * OP_W;
   localparam int unsigned PP_LO = 2 * CP_W;
   localparam int unsigned S1_LO = PP_LO + 4 * OP_W;
   localparam int unsigned S2_LO = S1_LO + OP_W + 1;
   localparam int unsigned MG_PT = S2_LO + 3;

   if (OP_W != 4) begin : g_bad_w
      $error("rvm_pp_mult: OP_W must be 4");
   end
   if (NPTS > (1 << SEL_W)) begin : g_bad_sel
      $error("rvm_pp_mult: selector too narrow");
   end

   // Fault points: raw line values and their possibly-inverted versions
   logic [NPTS-1:0] pt_raw, pt, fmask;

   if (INJECT) begin : g_inj
      always_comb begin
         fmask = '0;
         if (flt_en && (flt_sel < SEL_W'(NPTS)))
            fmask[flt_sel] = 1'b1;
      end
   end else begin : g_noinj
      assign fmask = '0;
   end

   assign pt = pt_raw ^ fmask;

   // Stage 0: fan each operand bit out to two copies
   logic [CP_W-1:0] src, cp0, cp1, cp_g;
   assign src = {op_b, op_a};

   for (genvar i = 0; i < CP_W; i++) begin : g_copy
      logic [2:0] d;
      assign d       = pp_dup(src[i], 1'b0, 1'b0);
      assign cp0[i]  = d[0];
      assign cp1[i]  = d[1];
      assign cp_g[i] = d[2];
   end

   assign pt_raw[CP_W-1:0]      = cp0;
   assign pt_raw[2*CP_W-1:CP_W] = cp1;

   logic [CP_W-1:0] fc0, fc1;
   assign fc0 = pt[CP_W-1:0];
   assign fc1 = pt[2*CP_W-1:CP_W];

   // Stage 1: four sub-multipliers; k: 0 = lo*lo, 1 = hi*lo, 2 = lo*hi, 3 = hi*hi
   logic [HALF-1:0]      xin [4];
   logic [HALF-1:0]      yin [4];
   logic [3:0]           mq  [4];
   logic [3:0]           mf  [4];
   logic [MUL2_GARB-1:0] mg  [4];

   assign xin[0] = fc0[HALF-1:0];
   assign yin[0] = fc0[OP_W+HALF-1:OP_W];
   assign xin[1] = fc0[OP_W-1:HALF];
   assign yin[1] = fc1[OP_W+HALF-1:OP_W];
   assign xin[2] = fc1[HALF-1:0];
   assign yin[2] = fc0[CP_W-1:OP_W+HALF];
   assign xin[3] = fc1[OP_W-1:HALF];
   assign yin[3] = fc1[CP_W-1:OP_W+HALF];

   for (genvar k = 0; k < 4; k++) begin : g_mul
      rvm_mul2 u_mul2 (
         .x (xin[k]),
         .y (yin[k]),
         .m (mq[k]),
         .g (mg[k])
      );
      assign pt_raw[PP_LO+4*k +: 4] = mq[k];
      assign mf[k] = pt[PP_LO+4*k +: 4];
   end

   // Stage 2: middle terms
   logic [OP_W-1:0]  s1, s2, s3;
   logic             c1, c2, c3;
   logic [RCA_G-1:0] g1, g2, g3;

   rvm_rca #(.N(OP_W)) u_add_mid (
      .x  (mf[1]),
      .y  (mf[2]),
      .s  (s1),
      .co (c1),
      .g  (g1)
   );

   assign pt_raw[S1_LO +: OP_W+1] = {c1, s1};

   rvm_rca #(.N(OP_W)) u_add_low (
      .x  (pt[S1_LO +: OP_W]),
      .y  ({2'b00, mf[0][3:2]}),
      .s  (s2),
      .co (c2),
      .g  (g2)
   );

   assign pt_raw[S2_LO +: 3] = {c2, s2[3:2]};

   // The two middle carries are never high together; merge them with a copy cell
   logic [2:0] mrg;
   assign mrg = pp_dup(pt[S1_LO+OP_W], pt[S2_LO+2], 1'b0);
   assign pt_raw[MG_PT] = mrg[1];

   // Stage 3: upper nibble
   rvm_rca #(.N(OP_W)) u_add_hi (
      .x  (mf[3]),
      .y  ({1'b0, pt[MG_PT], pt[S2_LO +: 2]}),
      .s  (s3),
      .co (c3),
      .g  (g3)
   );

   assign prod = {s3, s2[1:0], mf[0][1:0]};
   assign garb = {mg[3], mg[2], mg[1], mg[0], cp_g, g3, g2, g1,
                  mrg[2], mrg[0], c3};

   // Ancillas all enter at 0, so input-side parity is the operand parity
   assign err = (^{op_a, op_b}) ^ (^{prod, garb});

endmodule

// File: rtl/rvm_pp_mult_chk.sv
module rvm_pp_mult_chk #(
   parameter int unsigned OP_W   = 4,
   parameter int unsigned SEL_W  = 6,
   parameter int unsigned GARB_W = 80,
   parameter int unsigned NPTS   = 41
) (
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic              flt_en,
   input logic [SEL_W-1:0]  flt_sel,
   input logic [2*OP_W-1:0] prod,
   input logic [GARB_W-1:0] garb,
   input logic              err
);

   logic in_rng;
   assign in_rng = flt_en && (flt_sel < SEL_W'(NPTS));

   always_comb begin
      if (!in_rng) begin
         // R1 R5
         prod_match_chk: assert (prod == (2*OP_W)'(op_a) * (2*OP_W)'(op_b))
            else $error("product mismatch");
         // R2 R5 R6
         flag_quiet_chk: assert (!err)
            else $error("flag raised without a fault");
         // R3
         parity_kept_chk: assert ((^{op_a, op_b}) == (^{prod, garb}))
            else $error("parity not conserved");
      end else begin
         // R4
         flag_raised_chk: assert (err)
            else $error("injected fault not flagged");
      end
   end

endmodule

bind rvm_pp_mult rvm_pp_mult_chk #(
   .OP_W   (OP_W),
   .SEL_W  (SEL_W),
   .GARB_W (GARB_W),
   .NPTS   (NPTS)
) u_chk (
   .op_a    (op_a),
   .op_b    (op_b),
   .flt_en  (flt_en),
   .flt_sel (flt_sel),
   .prod    (prod),
   .garb    (garb),
   .err     (err)
);

// File: tb/rvm_pp_mult_test.sv
module rvm_pp_mult_test;

   localparam int NPTS = 41;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_a = '0, op_b = '0;
   logic       flt_en = 1'b0;
   logic [5:0] flt_sel = '0;
   logic [7:0] prod;
   logic [79:0] garb;
   logic       err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   rvm_pp_mult uut (
      .op_a    (op_a),
      .op_b    (op_b),
      .flt_en  (flt_en),
      .flt_sel (flt_sel),
      .prod    (prod),
      .garb    (garb),
      .err     (err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d en=%0d sel=%0d)",
                  req, act, exp, op_a, op_b, flt_en, flt_sel);
      end
   endtask

   // Drive just after a rising edge, compare against the model at the falling edge
   task automatic step(input int a, input int b, input bit en, input int sel);
      @(posedge clk);
      #1;
      op_a    = 4'(a);
      op_b    = 4'(b);
      flt_en  = en;
      flt_sel = 6'(sel);
      @(negedge clk);
   endtask

   task automatic expect_clean(input string req);
      int exp_p;
      exp_p = int'(op_a) * int'(op_b);
      check(int'(prod) == exp_p, req, int'(prod), exp_p);
      check(err == 1'b0, req, int'(err), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset-time idle state: zero operands, injection off
      check(prod == 8'd0, "R1 idle", int'(prod), 0);
      check(err == 1'b0, "R2 idle", int'(err), 0);

      // R1 R2 R3: full operand sweep with injection off
      for (int i = 0; i < 256; i++) begin
         step(i % 16, i / 16, 1'b0, 0);
         expect_clean("R1_R2");
         check((^{op_a, op_b}) == (^{prod, garb}), "R3",
               int'(^{prod, garb}), int'(^{op_a, op_b}));
      end

      // R4: every fault point under several operand patterns
      for (int pat = 0; pat < 4; pat++) begin
         for (int s = 0; s < NPTS; s++) begin
            int a, b;
            a = (pat == 0) ? 0 : (pat == 1) ? 15 : (pat == 2) ? 9 : 5;
            b = (pat == 0) ? 0 : (pat == 1) ? 15 : (pat == 2) ? 6 : 11;
            step(a, b, 1'b1, s);
            check(err == 1'b1, "R4", int'(err), 1);
         end
      end

      // R5: out-of-range selectors leave the block untouched
      for (int s = NPTS; s < 64; s++) begin
         step((s * 7) % 16, (s * 3) % 16, 1'b1, s);
         expect_clean("R5");
      end

      // R6: selector ignored while injection is disabled
      for (int s = 0; s < 64; s += 5) begin
         step((s * 5 + 3) % 16, (15 - s) & 15, 1'b0, s);
         expect_clean("R6");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule